// File: doc/BRIEF.md
# Shadow-Loaded PWM Generator

This block turns a normalized unsigned control word into a fixed-period pulse train that drives an external power stage. The control word is read as an unsigned fraction in [0, 1). It is scaled by the period length into a duty count and held in a pending register. The duty count moves into the active compare register only at the boundary between two periods. A free-running counter sets the period, and the output stays high while the counter is below the active duty count. Because duty updates wait for the boundary, no period is ever shortened or stretched by a change that arrives in the middle of it.

A supervisor drives two inputs that gate the block. When the safe request is raised, or the enable is removed, the pin goes low on the next cycle and both duty registers are cleared. The counter and the period strobe keep running in that state, so the timing base is never lost. After the gate is lifted, the pin stays low until a boundary has loaded a fresh duty value.

Top module: `shadow_pwm`

## Requirements
- R1: The duty count is D = (u*N + 2^(W-1)) >> W, which is the control word u (W-bit unsigned, value u/2^W) times the period N, rounded to the nearest count. With N <= 2^(W-1), the all-ones word gives D = N.
- R2: The counter runs 0, 1, ..., N-1 and then returns to 0 with no gaps. It never stops, whatever the enable and safe inputs are doing.
- R3: `wrap_o` is high for exactly one cycle in every N: the last cycle of each period, while the count is N-1. After reset it first goes high in the (N-1)th cycle.
- R4: In each period the pin is high for the first D cycles and low for the remaining N-D. D = 0 keeps the pin low. D = N keeps it high without a break across the boundary.
- R5: A control word applied in the middle of a period leaves the rest of that period unchanged. A word that has been held since before the last cycle of the previous period decides the next period.
- R6: When `safe_i` is high or `en_i` is low at a clock edge, `pwm_o` is low after that edge. The counter and `wrap_o` keep their cadence while this holds.
- R7: While gated off, the pending and active duty registers are cleared. If the gate is lifted in a cycle other than the last one of a period, the pin stays low for the rest of that period. The next period then uses the held control word.
- R8: During and right after reset, `pwm_o` and `wrap_o` are low and the count is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | CTRL_W | Control word, unsigned fraction u/2^CTRL_W |
| en_i | input | 1 | Enable; low forces the pin low |
| safe_i | input | 1 | Force-safe request from the supervisor |
| pwm_o | output | 1 | Pulse output |
| wrap_o | output | 1 | High in the last cycle of each period |

## Verification
The bench uses a 6-bit control word and a 10-cycle period. It sweeps every control word and checks every cycle position of a settled period. This separates rounding from truncation and pins down the D = 0 and D = N extremes. A word change made at position 1 of a period must leave that period at the old duty and give the next one the new duty, which is how the boundary loading is distinguished from immediate loading. The safe request and the enable are each dropped in the middle of a pulse and lifted just after a boundary. This shows the pin dropping on the next cycle, the strobe keeping its cadence, and the cleared registers holding the pin low for the remainder of the period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic [1:0] {
        GATE_RUN  = 2'd0,
        GATE_SAFE = 2'd1,
        GATE_OFF  = 2'd2
    } gate_e;

    // The safe request takes priority over the enable when both gate the output.
    function automatic gate_e gate_of(input logic en, input logic safe);
        if (safe)
            return GATE_SAFE;
        else if (!en)
            return GATE_OFF;
        return GATE_RUN;
    endfunction

endpackage

// File: rtl/pwm_duty_scale.sv
module pwm_duty_scale #(
    parameter int CTRL_W = 8,
    parameter int PERIOD = 100,
    parameter int DUTY_W = 7
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    output logic [DUTY_W-1:0] pend_o
);
    localparam int PROD_W = CTRL_W + DUTY_W;
    localparam logic [PROD_W-1:0] HALF  = PROD_W'(1) << (CTRL_W - 1);
    localparam logic [PROD_W-1:0] PER_P = PROD_W'(PERIOD);

    typedef struct packed {
        logic [DUTY_W-1:0] pend;
    } scale_st_t;

    scale_st_t s_d, s_q;
    logic [PROD_W-1:0] prod_d;
    logic [PROD_W-1:0] rnd_d;

    always_comb begin
        s_d    = s_q;
        prod_d = PROD_W'(ctrl_i) * PER_P;
        rnd_d  = prod_d + HALF;
        if (!run_i)
            s_d.pend = '0;
        else
            s_d.pend = rnd_d[CTRL_W +: DUTY_W];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign pend_o = s_q.pend;

    // R1: a scaled duty never exceeds the period
    a_r1_pend_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.pend <= DUTY_W'(PERIOD));

    // R7: gating off empties the pending register
    a_r7_pend_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (s_q.pend == '0));

endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
    parameter int PERIOD = 100,
    parameter int CNT_W  = 7
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    output logic [CNT_W-1:0] cnt_nxt_o,
    output logic             at_end_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             wrap;
    } ctr_st_t;

    ctr_st_t s_d, s_q;
    logic    end_d;

    always_comb begin
        s_d   = s_q;
        end_d = (s_q.cnt == LAST);
        if (end_d)
            s_d.cnt = '0;
        else
            s_d.cnt = s_q.cnt + CNT_W'(1);
        s_d.wrap = (s_d.cnt == LAST);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign cnt_nxt_o = s_d.cnt;
    assign at_end_o  = end_d;
    assign wrap_o    = s_q.wrap;

    // R2: after the last count the counter returns to zero
    a_r2_cnt_returns: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.cnt == LAST) |=> (s_q.cnt == '0));

    // R2: below the last count the counter advances by one
    a_r2_cnt_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.cnt != LAST) |=> (s_q.cnt == $past(s_q.cnt) + CNT_W'(1)));

    // R2: the count stays inside the period
    a_r2_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.cnt <= LAST);

    // R3: the strobe never lasts two cycles
    a_r3_wrap_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.wrap |=> !s_q.wrap);

endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
    parameter int PERIOD = 100,
    parameter int DUTY_W = 7
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic              at_end_i,
    input  logic [DUTY_W-1:0] cnt_nxt_i,
    input  logic [DUTY_W-1:0] pend_i,
    output logic              pwm_o
);
    typedef struct packed {
        logic [DUTY_W-1:0] act;
        logic              pwm;
    } cmp_st_t;

    cmp_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!run_i)
            s_d.act = '0;
        else if (at_end_i)
            s_d.act = pend_i;
        // The registered pin matches the compare of the count it will sit beside.
        s_d.pwm = run_i && (cnt_nxt_i < s_d.act);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign pwm_o = s_q.pwm;

    // R5: the active duty only moves at a boundary
    a_r5_act_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !at_end_i) |=> $stable(s_q.act));

    // R6: gating off drops the pin after one edge
    a_r6_gate_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> !s_q.pwm);

    // R7: gating off empties the active register
    a_r7_act_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (s_q.act == '0));

    // R4: a pulse can only begin at the start of a period
    a_r4_rise_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(s_q.pwm) |-> $past(at_end_i));

    // R1: the active duty never exceeds the period
    a_r1_act_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.act <= DUTY_W'(PERIOD));

endmodule

// File: rtl/shadow_pwm.sv
module shadow_pwm #(
    parameter int CTRL_W = 8,
    parameter int PERIOD = 100
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic              en_i,
    input  logic              safe_i,
    output logic              pwm_o,
    output logic              wrap_o
);
    import pwm_pkg::*;

    localparam int DUTY_W = $clog2(PERIOD + 1);

    gate_e             gate;
    logic              run;
    logic [DUTY_W-1:0] pend;
    logic [DUTY_W-1:0] cnt_nxt;
    logic              at_end;

    always_comb begin
        gate = gate_of(en_i, safe_i);
        run  = (gate == GATE_RUN);
    end

    pwm_duty_scale #(
        .CTRL_W (CTRL_W),
        .PERIOD (PERIOD),
        .DUTY_W (DUTY_W)
    ) u_scale (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (run),
        .ctrl_i (ctrl_i),
        .pend_o (pend)
    );

    pwm_period_ctr #(
        .PERIOD (PERIOD),
        .CNT_W  (DUTY_W)
    ) u_ctr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .cnt_nxt_o (cnt_nxt),
        .at_end_o  (at_end),
        .wrap_o    (wrap_o)
    );

    pwm_compare #(
        .PERIOD (PERIOD),
        .DUTY_W (DUTY_W)
    ) u_cmp (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (run),
        .at_end_i  (at_end),
        .cnt_nxt_i (cnt_nxt),
        .pend_i    (pend),
        .pwm_o     (pwm_o)
    );

    // R6: a safe request at an edge leaves the pin low after it
    a_r6_safe_forces_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        safe_i |=> !pwm_o);

endmodule

// File: tb/shadow_pwm_tb.sv
module shadow_pwm_tb;
    localparam int W = 6;
    localparam int N = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] ctrl = '0;
    logic         en = 1'b1;
    logic         safe = 1'b0;
    logic         pwm;
    logic         wrap;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    shadow_pwm #(.CTRL_W(W), .PERIOD(N)) u_dut (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .ctrl_i (ctrl),
        .en_i   (en),
        .safe_i (safe),
        .pwm_o  (pwm),
        .wrap_o (wrap)
    );

    function automatic int duty_of(input int u);
        return (u * N + (1 << (W - 1))) >> W;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_wrap();
        do @(negedge clk); while (!wrap);
    endtask

    // Checks one full period starting right after a wrap sample.
    task automatic measure(input int d, input string req);
        for (int p = 0; p < N; p++) begin
            @(negedge clk);
            check(pwm == (p < d), req, int'(pwm), int'(p < d));
            check(wrap == (p == N - 1), "R3 wrap position", int'(wrap), int'(p == N - 1));
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        int wraps;
        // R8: reset state
        repeat (3) @(negedge clk);
        check(pwm == 1'b0, "R8 pwm in reset", int'(pwm), 0);
        check(wrap == 1'b0, "R8 wrap in reset", int'(wrap), 0);
        rst_n = 1'b1;
        for (int k = 1; k <= N - 1; k++) begin
            @(negedge clk);
            check(wrap == (k == N - 1), "R3 first wrap after reset", int'(wrap), int'(k == N - 1));
            check(pwm == 1'b0, "R8 pwm low after reset", int'(pwm), 0);
        end

        // R1 / R4: sweep every control word
        for (int v = 0; v < (1 << W); v++) begin
            ctrl = W'(v);
            wait_wrap();
            wait_wrap();
            if (v == 0 || v == (1 << W) - 1)
                measure(duty_of(v), "R4 extreme duty");
            else
                measure(duty_of(v), "R1 duty sweep");
        end
        // R4: full duty stays high across the boundary
        ctrl = W'((1 << W) - 1);
        check(duty_of((1 << W) - 1) == N, "R1 full scale reaches N", duty_of((1 << W) - 1), N);
        measure(N, "R4 full duty next period");

        // R5: mid-period change waits for the boundary
        ctrl = W'(10);
        wait_wrap();
        wait_wrap();
        for (int p = 0; p < N; p++) begin
            @(negedge clk);
            check(pwm == (p < duty_of(10)), "R5 old duty kept", int'(pwm), int'(p < duty_of(10)));
            if (p == 1) ctrl = W'(50);
        end
        measure(duty_of(50), "R5 new duty next period");

        // R6 / R7: safe request mid-pulse
        ctrl = W'((1 << W) - 1);
        wait_wrap();
        wait_wrap();
        @(negedge clk);
        @(negedge clk);
        check(pwm == 1'b1, "R6 high before safe", int'(pwm), 1);
        safe = 1'b1;
        wraps = 0;
        for (int k = 0; k < 2 * N; k++) begin
            @(negedge clk);
            check(pwm == 1'b0, "R6 safe forces low", int'(pwm), 0);
            if (wrap) wraps++;
        end
        check(wraps == 2, "R6 wrap cadence while safe", wraps, 2);
        wait_wrap();
        @(negedge clk);
        safe = 1'b0;
        for (int p = 1; p < N; p++) begin
            @(negedge clk);
            check(pwm == 1'b0, "R7 low after safe release", int'(pwm), 0);
        end
        measure(N, "R7 resume after safe");

        // R6 / R7: enable removed mid-pulse
        ctrl = W'(20);
        wait_wrap();
        wait_wrap();
        @(negedge clk);
        @(negedge clk);
        check(pwm == 1'b1, "R6 high before disable", int'(pwm), 1);
        en = 1'b0;
        wraps = 0;
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            check(pwm == 1'b0, "R6 disable forces low", int'(pwm), 0);
            if (wrap) wraps++;
        end
        check(wraps == 1, "R2 counter runs while disabled", wraps, 1);
        wait_wrap();
        @(negedge clk);
        en = 1'b1;
        for (int p = 1; p < N; p++) begin
            @(negedge clk);
            check(pwm == 1'b0, "R7 low after enable", int'(pwm), 0);
        end
        measure(duty_of(20), "R7 resume after enable");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule